// File: doc/BRIEF.md
# Integer ALU with Trapping Overflow

This block is the combinational integer execution unit of a load-store RISC pipeline. On each evaluation it takes two 32-bit operands, a 5-bit constant shift distance and a 5-bit operation code. It returns a 32-bit result and a flag that requests an overflow exception. There is no state inside the block. The caller places it between the operand-read and write-back stages and samples both outputs in the same cycle.

Addition and subtraction each come in two forms. The trapping form raises the overflow flag when the signed result does not fit. The non-trapping form computes the same value and never raises it. The block also provides the four bitwise operations, signed and unsigned compare-less-than, and shifts in three directions (left, logical right, arithmetic right). Each shift can take its distance from the constant field or from the first operand. The last operation moves a 16-bit constant into the upper half of the result.

The caller does any sign or zero extension of immediates before the operand reaches the block. The block does not multiply, divide or evaluate branch conditions.

Top module: `int_alu`

## Requirements
- R1: Opcode 0 (trapping add) and opcode 1 (non-trapping add) give result_o = a_i + b_i modulo 2^32.
- R2: Opcode 2 (trapping subtract) and opcode 3 (non-trapping subtract) give result_o = a_i - b_i modulo 2^32.
- R3: ovf_o is 1 for opcode 0 when a_i and b_i have the same sign bit (bit 31) and the sum's sign bit differs from it. It is 1 for opcode 2 when a_i and the inverted b_i have the same sign bit and the difference's sign bit differs from a_i's. Otherwise ovf_o is 0 for these two opcodes.
- R4: ovf_o is 0 for every opcode other than 0 and 2, including the non-trapping opcodes 1 and 3.
- R5: The bitwise opcodes are 4 = AND, 5 = OR, 6 = XOR and 7 = NOR (the inverse of OR), each applied to a_i and b_i.
- R6: Opcode 8 compares a_i and b_i as two's-complement numbers. result_o is 1 when a_i is smaller and 0 otherwise, and bits 31..1 of result_o are always zero.
- R7: Opcode 9 compares a_i and b_i as unsigned numbers. result_o is 1 when a_i is smaller and 0 otherwise, and bits 31..1 of result_o are always zero.
- R8: Opcodes 10 (left), 11 (logical right, zero fill) and 12 (arithmetic right, fill with b_i bit 31) shift b_i by shamt_i.
- R9: Opcodes 13, 14 and 15 perform the same three shifts on b_i by a_i[4:0]. Bits 31..5 of a_i have no effect on the result.
- R10: Opcode 16 gives result_o = {b_i[15:0], 16'h0000}. a_i, shamt_i and b_i[31:16] have no effect on the result.
- R11: Opcodes 17 to 31 give result_o = 0 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code, encoded as listed in the requirements |
| a_i | input | 32 | First operand; supplies the distance for the register-distance shifts |
| b_i | input | 32 | Second operand; the value shifted; its low half is the upper-half constant |
| shamt_i | input | 5 | Constant shift distance |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Overflow exception request |

## Verification
The bound checker evaluates structural rules on every input change:
- the overflow flag may appear only for the two trapping opcodes,
- when it appears, the operand and result sign bits must match the overflow pattern for add or subtract,
- compare results keep bits 31..1 at zero,
- the upper-half-constant result keeps its low half at zero,
- unused opcodes produce zero.

These rules cannot show that any value is numerically right. Correct sums, differences, comparison outcomes, shift fill bits and the ignored upper bits of a register distance are shown only by the bench. The bench compares random and corner-case vectors for every opcode against its own reference model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned XLEN_DEF = 32;
  localparam int unsigned OPW      = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

  // Signed overflow rule: operands agree in sign, result disagrees.
  function automatic logic f_sign_ovf(input logic sa, input logic sb_eff,
                                      input logic ss);
    return (sa == sb_eff) && (ss != sa);
  endfunction

  // Less-than from a subtraction: signs differ -> a's sign decides.
  function automatic logic f_lt_signed(input logic sa, input logic sb,
                                       input logic sdiff);
    return (sa != sb) ? sa : sdiff;
  endfunction

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  input  logic            trap,
  output logic [XLEN-1:0] sum,
  output logic            carry,
  output logic            ovf_raw,
  output logic            ovf
);
  import int_alu_pkg::*;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
  assign sum   = wide[XLEN-1:0];
  assign carry = wide[XLEN];

  assign ovf_raw = f_sign_ovf(a[XLEN-1], b_eff[XLEN-1], sum[XLEN-1]);
  assign ovf     = trap & ovf_raw;

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]              a,
  input  logic [XLEN-1:0]              b,
  input  int_alu_pkg::logic_sel_e      sel,
  output logic [XLEN-1:0]              y
);
  import int_alu_pkg::*;

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      LG_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic            a_msb,
  input  logic            b_msb,
  input  logic            diff_msb,
  input  logic            carry,
  input  logic            is_unsigned,
  output logic [XLEN-1:0] y,
  output logic            lt
);
  import int_alu_pkg::*;

  logic lt_s;
  logic lt_u;

  assign lt_s = f_lt_signed(a_msb, b_msb, diff_msb);
  // a + ~b + 1 carries out exactly when a >= b unsigned.
  assign lt_u = ~carry;
  assign lt   = is_unsigned ? lt_u : lt_s;
  assign y    = {{(XLEN-1){1'b0}}, lt};

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  input  logic            arith,
  output logic [XLEN-1:0] y
);

  function automatic logic [XLEN-1:0] f_rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < int'(XLEN); i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  logic            fill;
  logic [XLEN-1:0] stg [SHW+1];

  assign fill   = arith & ~left & val[XLEN-1];
  assign stg[0] = left ? f_rev(val) : val;

  // Logarithmic right shifter; a left shift runs through it bit-reversed.
  for (genvar k = 0; k < int'(SHW); k++) begin : g_stage
    localparam int unsigned D = 2 ** k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
  end

  assign y = left ? f_rev(stg[SHW]) : stg[SHW];

endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int unsigned XLEN = int_alu_pkg::XLEN_DEF,
  localparam int unsigned SHW  = $clog2(XLEN),
  localparam int unsigned HALF = XLEN / 2
) (
  input  logic [4:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o
);
  import int_alu_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Decoded control, named so the checker and waveforms can see them.
  logic       dec_sub, dec_trap, dec_unsigned_cmp;
  logic       dec_shift_left, dec_shift_arith, dec_shift_var;
  logic_sel_e dec_lsel;

  always_comb begin
    dec_sub          = (op == OP_SUB) || (op == OP_SUBU) ||
                       (op == OP_SLT) || (op == OP_SLTU);
    dec_trap         = (op == OP_ADD) || (op == OP_SUB);
    dec_unsigned_cmp = (op == OP_SLTU);
    dec_shift_left   = (op == OP_SLL) || (op == OP_SLLV);
    dec_shift_arith  = (op == OP_SRA) || (op == OP_SRAV);
    dec_shift_var    = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    unique case (op)
      OP_OR:   dec_lsel = LG_OR;
      OP_XOR:  dec_lsel = LG_XOR;
      OP_NOR:  dec_lsel = LG_NOR;
      default: dec_lsel = LG_AND;
    endcase
  end

  // Shared adder: add, subtract and both compares.
  logic [XLEN-1:0] ev_sum;
  logic            ev_carry, ev_ovf_raw, ev_ovf;

  int_alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a       (a_i),
    .b       (b_i),
    .sub     (dec_sub),
    .trap    (dec_trap),
    .sum     (ev_sum),
    .carry   (ev_carry),
    .ovf_raw (ev_ovf_raw),
    .ovf     (ev_ovf)
  );

  logic [XLEN-1:0] ev_cmp;
  logic            ev_lt;

  int_alu_cmp #(.XLEN(XLEN)) u_cmp (
    .a_msb       (a_i[XLEN-1]),
    .b_msb       (b_i[XLEN-1]),
    .diff_msb    (ev_sum[XLEN-1]),
    .carry       (ev_carry),
    .is_unsigned (dec_unsigned_cmp),
    .y           (ev_cmp),
    .lt          (ev_lt)
  );

  logic [XLEN-1:0] ev_logic;

  int_alu_logic #(.XLEN(XLEN)) u_logic (
    .a   (a_i),
    .b   (b_i),
    .sel (dec_lsel),
    .y   (ev_logic)
  );

  logic [SHW-1:0]  ev_amt;
  logic [XLEN-1:0] ev_shift;

  assign ev_amt = dec_shift_var ? a_i[SHW-1:0] : shamt_i;

  int_alu_shift #(.XLEN(XLEN)) u_shift (
    .val   (b_i),
    .amt   (ev_amt),
    .left  (dec_shift_left),
    .arith (dec_shift_arith),
    .y     (ev_shift)
  );

  logic [XLEN-1:0] ev_upper;
  assign ev_upper = {b_i[HALF-1:0], {HALF{1'b0}}};

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU:    result_o = ev_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:       result_o = ev_logic;
      OP_SLT, OP_SLTU:                     result_o = ev_cmp;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:           result_o = ev_shift;
      OP_LUI:                              result_o = ev_upper;
      default:                             result_o = '0;
    endcase
  end

  assign ovf_o = ev_ovf;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned HALF = XLEN / 2
) (
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] result_o,
  input logic            ovf_o
);

  always_comb begin
    // R4: only opcodes 0 and 2 may request the exception.
    if (ovf_o)
      assert_no_overflow_R4: assert (op_i == 5'd0 || op_i == 5'd2)
        else $error("overflow flag on non-trapping opcode %0d", op_i);

    // R3: a flagged add shows equal operand signs and a flipped result sign.
    if (ovf_o && op_i == 5'd0)
      assert_add_ovf_sign_R3: assert (a_i[XLEN-1] == b_i[XLEN-1] &&
                                      result_o[XLEN-1] != a_i[XLEN-1])
        else $error("add overflow flag without sign pattern");

    // R3: a flagged subtract shows differing operand signs and a flipped result.
    if (ovf_o && op_i == 5'd2)
      assert_sub_ovf_sign_R3: assert (a_i[XLEN-1] != b_i[XLEN-1] &&
                                      result_o[XLEN-1] != a_i[XLEN-1])
        else $error("subtract overflow flag without sign pattern");

    // R6, R7: comparisons leave only bit 0 free.
    if (op_i == 5'd8 || op_i == 5'd9)
      assert_cmp_upper_zero_R6_R7: assert (result_o[XLEN-1:1] == '0)
        else $error("compare result has upper bits set");

    // R10: upper-half constant keeps the low half clear.
    if (op_i == 5'd16)
      assert_upper_low_zero_R10: assert (result_o[HALF-1:0] == '0)
        else $error("upper-half constant low half not zero");

    // R11: unused opcodes are silent.
    if (op_i >= 5'd17)
      assert_unused_silent_R11: assert (result_o == '0 && !ovf_o)
        else $error("unused opcode produced output");
  end

endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN)) u_chk (
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .ovf_o    (ovf_o)
);

// File: tb/tb_int_alu.sv
module tb_int_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [31:0] res;
  logic        ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  int_alu dut (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .shamt_i  (sh),
    .result_o (res),
    .ovf_o    (ovf)
  );

  // Reference model written from the requirements.
  function automatic logic [31:0] ref_res(input logic [4:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input logic [4:0] s);
    logic [63:0] xs;
    case (o)
      5'd0, 5'd1: return x + y;
      5'd2, 5'd3: return x - y;
      5'd4:  return x & y;
      5'd5:  return x | y;
      5'd6:  return x ^ y;
      5'd7:  return ~(x | y);
      5'd8:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'd9:  return (x < y) ? 32'd1 : 32'd0;
      5'd10: return y << s;
      5'd11: return y >> s;
      5'd12: begin xs = {{32{y[31]}}, y} >> s; return xs[31:0]; end
      5'd13: return y << x[4:0];
      5'd14: return y >> x[4:0];
      5'd15: begin xs = {{32{y[31]}}, y} >> x[4:0]; return xs[31:0]; end
      5'd16: return y * 32'd65536;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [4:0] o, input logic [31:0] x,
                                   input logic [31:0] y);
    logic signed [32:0] w;
    if (o == 5'd0) begin
      w = $signed({x[31], x}) + $signed({y[31], y});
      return w[32] != w[31];
    end
    if (o == 5'd2) begin
      w = $signed({x[31], x}) - $signed({y[31], y});
      return w[32] != w[31];
    end
    return 1'b0;
  endfunction

  function automatic string res_tag(input logic [4:0] o);
    if (o <= 5'd1)  return "R1";
    if (o <= 5'd3)  return "R2";
    if (o <= 5'd7)  return "R5";
    if (o == 5'd8)  return "R6";
    if (o == 5'd9)  return "R7";
    if (o <= 5'd12) return "R8";
    if (o <= 5'd15) return "R9";
    if (o == 5'd16) return "R10";
    return "R11";
  endfunction

  task automatic apply(input logic [4:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [4:0] s);
    logic [31:0] er;
    logic        eo;
    string       ot;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #1;
    er = ref_res(o, x, y, s);
    eo = ref_ovf(o, x, y);
    n_checks++;
    if (res !== er) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h",
               res_tag(o), o, x, y, s, res, er);
    end
    ot = (o == 5'd0 || o == 5'd2) ? "R3" : ((o >= 5'd17) ? "R11" : "R4");
    n_checks++;
    if (ovf !== eo) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b",
               ot, o, x, y, ovf, eo);
    end
  endtask

  function automatic logic [31:0] pick(input logic [31:0] r);
    case (r[2:0])
      3'd0: return 32'h0000_0000;
      3'd1: return 32'h0000_0001;
      3'd2: return 32'h7fff_ffff;
      3'd3: return 32'h8000_0000;
      3'd4: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    op = 5'd0; a = '0; b = '0; sh = '0;
    void'($urandom(32'd20240126));
    repeat (3) @(posedge clk);
    // Reset state of the stimulus: zero add gives zero, no flag (R1).
    apply(5'd0, 32'd0, 32'd0, 5'd0);
    rst_n = 1'b1;

    // Directed corners.
    apply(5'd0, 32'h7fff_ffff, 32'd1, 5'd0);          // R3 add overflow
    apply(5'd1, 32'h7fff_ffff, 32'd1, 5'd0);          // R4 non-trapping
    apply(5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);  // R3 negative overflow
    apply(5'd2, 32'h8000_0000, 32'd1, 5'd0);          // R3 subtract overflow
    apply(5'd3, 32'h8000_0000, 32'd1, 5'd0);          // R4 non-trapping
    apply(5'd2, 32'h0000_0000, 32'h8000_0000, 5'd0);  // R3 0 - min
    apply(5'd0, 32'hffff_ffff, 32'd1, 5'd0);          // R1 wrap, no overflow
    apply(5'd8, 32'hffff_ffff, 32'd1, 5'd0);          // R6 -1 < 1
    apply(5'd9, 32'hffff_ffff, 32'd1, 5'd0);          // R7 big unsigned
    apply(5'd8, 32'h8000_0000, 32'h7fff_ffff, 5'd0);  // R6 sign differs
    apply(5'd9, 32'h1234_5678, 32'h1234_5678, 5'd0);  // R7 equal
    apply(5'd12, 32'd0, 32'h8000_0000, 5'd31);        // R8 arith fill
    apply(5'd11, 32'd0, 32'h8000_0000, 5'd31);        // R8 zero fill
    apply(5'd10, 32'd0, 32'h0000_0001, 5'd31);        // R8 left max
    apply(5'd15, 32'hffff_ffe3, 32'hf000_0000, 5'd0); // R9 upper a ignored
    apply(5'd13, 32'h0000_0020, 32'h0000_0001, 5'd7); // R9 amount 0
    apply(5'd16, 32'hdead_beef, 32'h5555_abcd, 5'd9); // R10
    apply(5'd7, 32'd0, 32'd0, 5'd0);                  // R5 NOR
    apply(5'd20, 32'hffff_ffff, 32'hffff_ffff, 5'd3); // R11
    apply(5'd31, 32'h7fff_ffff, 32'd1, 5'd0);         // R11

    // Constrained random over all opcodes.
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[4:0], pick($urandom), pick($urandom), 5'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule